// File: doc/BRIEF.md
# Integer and Single-Precision Float Converter with Selectable Rounding

This block converts a 32-bit signed integer into an IEEE-754 single-precision value, or a single-precision value into a 32-bit signed integer. A one-bit operation select picks the direction. A two-bit rounding-mode input, taken from the control/status register, sets how any inexact result is rounded, in both directions.

A caller presents the operand, the direction and the mode together with a one-cycle start strobe. The converted value and a valid flag appear on registered outputs on the next clock edge. For float-to-integer, NaN and any magnitude that cannot be represented saturate to the largest or smallest integer. Subnormal and other tiny inputs round to zero, or to plus or minus one when a directed mode calls for it.

Top module: `cvt_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, is low otherwise, and is low after reset.
- R2: `result_o` changes only on the clock edge that samples `start_i` high, and holds its value at all other edges. It is zero after reset.
- R3: With `op_i`=0, the operand is read as a signed 32-bit integer and converted to single precision. With `op_i`=1, the operand is read as single precision (sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0) and converted to a signed 32-bit integer.
- R4: With `rmode_i`=0, inexact results round to the nearest representable value, and exact ties go to the value with an even lowest bit.
- R5: With `rmode_i`=1, inexact results round toward zero.
- R6: With `rmode_i`=2, inexact results round toward positive infinity. With `rmode_i`=3, they round toward negative infinity.
- R7: Integer 0 converts to 0x00000000 (+0.0). Integer 0x80000000 converts exactly to 0xCF000000 (-2^31).
- R8: Float-to-integer of any NaN (exponent all ones, fraction nonzero, either sign) gives 0x7FFFFFFF.
- R9: Float-to-integer of an infinity, or of a magnitude of 2^31 or more, gives 0x7FFFFFFF for a positive input and 0x80000000 for a negative input.
- R10: Float-to-integer of a subnormal, or of any value below one in magnitude, gives 0, or +1/-1 (0xFFFFFFFF) when the mode rounds away from zero in that sign's direction. Either zero gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; samples the operand, direction and mode |
| op_i | input | 1 | Direction: 0 integer to float, 1 float to integer |
| operand_i | input | 32 | Source value |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| result_o | output | 32 | Converted value, registered |
| valid_o | output | 1 | High for one cycle when `result_o` holds a new result |

## Verification
Two effects can meet in a single conversion: a saturating or special-value override, and a rounding increment from the directed modes. Examples are a negative subnormal under round-down, or a value just below 2^31 under round-up. The bench drives these edges directly under every mode. It also drives random operands whose exponents are aimed at the exact-integer range, the fraction range and the saturation boundary. Each result is judged against a bench model that rounds by comparing the exact remainder with half an LSB. Back-to-back strobes and idle gaps with a changing operand show that the output register and the valid flag follow only the strobe.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_POS       = 2'd2,
    RM_NEG       = 2'd3
  } rmode_e;

  typedef enum logic {
    OP_I2F = 1'b0,
    OP_F2I = 1'b1
  } op_e;

  // magnitude increment decision from kept lsb, guard and sticky
  function automatic logic round_inc(input rmode_e rm, input logic sign,
                                     input logic lsb, input logic guard,
                                     input logic sticky);
    logic inexact;
    inexact = guard | sticky;
    case (rm)
      RM_NEAR_EVEN: round_inc = guard & (sticky | lsb);
      RM_ZERO:      round_inc = 1'b0;
      RM_POS:       round_inc = ~sign & inexact;
      default:      round_inc = sign & inexact;
    endcase
  endfunction
endpackage

// File: rtl/cvt_i2f.sv
module cvt_i2f
  import cvt_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [INT_W-1:0]           int_i,
  input  rmode_e                     rm_i,
  output logic [EXP_W+MAN_W:0]       fp_o
);
  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W = $clog2(INT_W);

  logic             sign;
  logic [INT_W-1:0] mag, norm;
  logic [LZ_W-1:0]  msb, lz;
  logic [MAN_W-1:0] mant;
  logic             lsb, guard, sticky, inc;
  logic [FP_W-2:0]  body;

  always_comb begin
    sign = int_i[INT_W-1];
    mag  = sign ? (~int_i + 1'b1) : int_i;
    msb  = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) msb = LZ_W'(i);
    end
    lz     = LZ_W'(INT_W - 1) - msb;
    norm   = mag << lz;
    mant   = norm[INT_W-2 -: MAN_W];
    lsb    = norm[INT_W-1-MAN_W];
    guard  = norm[INT_W-2-MAN_W];
    sticky = |norm[INT_W-3-MAN_W:0];
    inc    = round_inc(rm_i, sign, lsb, guard, sticky);
    // mantissa carry ripples into the exponent field
    body   = {EXP_W'(BIAS) + EXP_W'(msb), mant} + (FP_W-1)'(inc);
    fp_o   = norm[INT_W-1] ? {sign, body} : '0;
  end
endmodule

// File: rtl/cvt_f2i.sv
module cvt_f2i
  import cvt_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  input  rmode_e               rm_i,
  output logic [INT_W-1:0]     int_o
);
  localparam int FP_W     = 1 + EXP_W + MAN_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXACT_E  = BIAS + MAN_W;
  localparam int SAT_E    = BIAS + INT_W - 1;
  localparam int SIG_W    = MAN_W + 1;
  localparam int WV       = 2 * INT_W;
  localparam int DROP_LIM = INT_W + SIG_W;
  localparam logic [INT_W-1:0] SAT_HI = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_LO = {1'b1, {(INT_W-1){1'b0}}};

  logic             sign;
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic [SIG_W-1:0] sig;
  int               ee, rsh;
  logic [WV-1:0]    v, vs;
  logic [INT_W-1:0] ipart, mag;
  logic             guard, sticky, inc;

  always_comb begin
    sign   = fp_i[FP_W-1];
    e      = fp_i[FP_W-2:MAN_W];
    m      = fp_i[MAN_W-1:0];
    sig    = {|e, m};
    ee     = (e == '0) ? 1 : int'(e);
    v      = WV'(sig) << INT_W;
    vs     = '0;
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    rsh    = 0;
    if (ee >= EXACT_E) begin
      ipart = INT_W'(sig) << (ee - EXACT_E);
    end else begin
      rsh = EXACT_E - ee;
      if (rsh >= DROP_LIM) begin
        sticky = |sig;
      end else begin
        vs     = v >> rsh;
        ipart  = vs[WV-1:INT_W];
        guard  = vs[INT_W-1];
        sticky = |vs[INT_W-2:0];
      end
    end
    inc   = round_inc(rm_i, sign, ipart[0], guard, sticky);
    mag   = ipart + INT_W'(inc);
    int_o = sign ? -mag : mag;
    if (e == '1 && m != '0) int_o = SAT_HI;
    else if (int'(e) >= SAT_E) int_o = sign ? SAT_LO : SAT_HI;
  end
endmodule

// File: rtl/cvt_unit.sv
module cvt_unit
  import cvt_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [INT_W-1:0] operand_i,
  input  logic [1:0]       rmode_i,
  output logic [INT_W-1:0] result_o,
  output logic             valid_o
);
  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [INT_W-1:0] i2f_res, f2i_res;
  rmode_e           rm;

  assign rm = rmode_e'(rmode_i);

  cvt_i2f #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_i2f (
    .int_i (operand_i),
    .rm_i  (rm),
    .fp_o  (i2f_res)
  );

  cvt_f2i #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_f2i (
    .fp_i  (operand_i),
    .rm_i  (rm),
    .int_o (f2i_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= (op_e'(op_i) == OP_F2I) ? f2i_res : i2f_res;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o)); // R2
  AST_ZERO_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i && operand_i == '0) |=> result_o == '0); // R7
  AST_NAN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i && operand_i[FP_W-2:MAN_W] == '1 && operand_i[MAN_W-1:0] != '0)
    |=> result_o == {1'b0, {(INT_W-1){1'b1}}}); // R8
  AST_TRUNC_TINY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i && rmode_i == 2'd1 && int'(operand_i[FP_W-2:MAN_W]) < BIAS)
    |=> result_o == '0); // R5
endmodule

// File: tb/tb_cvt_unit.sv
`timescale 1ns/1ps
module tb_cvt_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  rmode_i = '0;
  logic [31:0] result_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cvt_unit dut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic rnd(logic [1:0] rm, logic s, logic odd, longint r, longint half);
    case (rm)
      2'd0:    return (r > half) || (r == half && odd);
      2'd1:    return 1'b0;
      2'd2:    return !s && r != 0;
      default: return s && r != 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_i2f(logic [31:0] x, logic [1:0] rm);
    longint sx, mag, q, r, half;
    logic s;
    int p, k;
    sx  = longint'($signed(x));
    s   = sx < 0;
    mag = s ? -sx : sx;
    if (mag == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    if (p <= 23) begin
      q = mag << (23 - p);
    end else begin
      k    = p - 23;
      q    = mag >> k;
      r    = mag - (q << k);
      half = 64'sd1 << (k - 1);
      q    = q + longint'(rnd(rm, s, q[0], r, half));
      if (q == (64'sd1 << 24)) begin q = q >> 1; p++; end
    end
    return {s, 8'(p + 127), q[22:0]};
  endfunction

  function automatic logic [31:0] ref_f2i(logic [31:0] x, logic [1:0] rm);
    logic s;
    int e, ee, k;
    longint sig, q, r, half;
    s = x[31];
    e = int'(x[30:23]);
    if (e == 255 && x[22:0] != 0) return 32'h7FFFFFFF;
    if (e >= 158) return s ? 32'h80000000 : 32'h7FFFFFFF;
    sig = longint'(x[22:0]) | ((e != 0) ? (64'sd1 << 23) : 64'sd0);
    ee  = (e == 0) ? 1 : e;
    if (ee >= 150) begin
      q = sig << (ee - 150);
    end else begin
      k = 150 - ee;
      if (k > 40) begin q = 0; r = sig; half = 64'sd1 << 40; end
      else begin q = sig >> k; r = sig - (q << k); half = 64'sd1 << (k - 1); end
      q = q + longint'(rnd(rm, s, q[0], r, half));
    end
    return s ? 32'(-q) : 32'(q);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic conv(string tag, logic op, logic [31:0] x, logic [1:0] rm, logic [31:0] exp);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; operand_i = x; rmode_i = rm;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R1 valid", {31'b0, valid_o}, 32'h1);
    check(tag, result_o, exp);
  endtask

  task automatic conv_ref(string tag, logic op, logic [31:0] x, logic [1:0] rm);
    conv(tag, op, x, rm, op ? ref_f2i(x, rm) : ref_i2f(x, rm));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", {31'b0, valid_o}, 32'h0);
    check("R2 reset result", result_o, 32'h0);
    rst_ni = 1'b1;

    // R7 zero and most negative integer
    conv("R7 int zero", 1'b0, 32'h0, 2'd2, 32'h0);
    conv("R7 int min", 1'b0, 32'h80000000, 2'd0, 32'hCF000000);
    // R3 exact small integers
    conv("R3 int 1", 1'b0, 32'd1, 2'd0, 32'h3F800000);
    conv("R3 int -3", 1'b0, 32'hFFFFFFFD, 2'd1, 32'hC0400000);
    // R4 ties to even, R5, R6 on 2^24+1 and 2^24+3
    conv("R4 tie down", 1'b0, 32'h01000001, 2'd0, 32'h4B800000);
    conv("R4 tie up", 1'b0, 32'h01000003, 2'd0, 32'h4B800002);
    conv("R5 i2f trunc", 1'b0, 32'h01000003, 2'd1, 32'h4B800001);
    conv("R6 i2f up", 1'b0, 32'h01000001, 2'd2, 32'h4B800001);
    conv("R6 i2f down neg", 1'b0, 32'hFEFFFFFF, 2'd3, 32'hCB800001);
    conv("R6 i2f up neg", 1'b0, 32'hFEFFFFFF, 2'd2, 32'hCB800000);
    conv("R4 i2f carry", 1'b0, 32'h7FFFFFFF, 2'd0, 32'h4F000000);
    // float to int, 2.5 / -2.5 / 3.5 / 1.5 / 0.5
    conv("R4 f2i 2.5", 1'b1, 32'h40200000, 2'd0, 32'd2);
    conv("R4 f2i 3.5", 1'b1, 32'h40600000, 2'd0, 32'd4);
    conv("R4 f2i 1.5", 1'b1, 32'h3FC00000, 2'd0, 32'd2);
    conv("R4 f2i -2.5", 1'b1, 32'hC0200000, 2'd0, 32'hFFFFFFFE);
    conv("R5 f2i -2.5", 1'b1, 32'hC0200000, 2'd1, 32'hFFFFFFFE);
    conv("R6 f2i 2.5 up", 1'b1, 32'h40200000, 2'd2, 32'd3);
    conv("R6 f2i -2.5 down", 1'b1, 32'hC0200000, 2'd3, 32'hFFFFFFFD);
    conv("R6 f2i -2.5 up", 1'b1, 32'hC0200000, 2'd2, 32'hFFFFFFFE);
    conv("R3 f2i big exact", 1'b1, 32'h4EFFFFFF, 2'd0, 32'h7FFFFF80);
    // R8 NaN, R9 saturation
    conv("R8 qnan", 1'b1, 32'h7FC00000, 2'd0, 32'h7FFFFFFF);
    conv("R8 neg nan", 1'b1, 32'hFF800001, 2'd3, 32'h7FFFFFFF);
    conv("R9 +inf", 1'b1, 32'h7F800000, 2'd1, 32'h7FFFFFFF);
    conv("R9 -inf", 1'b1, 32'hFF800000, 2'd1, 32'h80000000);
    conv("R9 2^31", 1'b1, 32'h4F000000, 2'd2, 32'h7FFFFFFF);
    conv("R9 -2^31", 1'b1, 32'hCF000000, 2'd0, 32'h80000000);
    conv("R9 1e10", 1'b1, 32'h501502F9, 2'd0, 32'h7FFFFFFF);
    // R10 subnormals, tiny values, zeros
    conv("R10 denorm near", 1'b1, 32'h00000001, 2'd0, 32'h0);
    conv("R10 denorm up", 1'b1, 32'h00000001, 2'd2, 32'h1);
    conv("R10 denorm down", 1'b1, 32'h00000001, 2'd3, 32'h0);
    conv("R10 neg denorm down", 1'b1, 32'h80000001, 2'd3, 32'hFFFFFFFF);
    conv("R10 neg denorm up", 1'b1, 32'h80000001, 2'd2, 32'h0);
    conv("R10 half near", 1'b1, 32'h3F000000, 2'd0, 32'h0);
    conv("R10 neg zero", 1'b1, 32'h80000000, 2'd3, 32'h0);

    // R1 / R2: idle cycles with changing inputs hold the result
    held = result_o;
    @(negedge clk_i);
    operand_i = 32'h12345678; op_i = 1'b0; rmode_i = 2'd2;
    @(negedge clk_i);
    check("R1 idle valid", {31'b0, valid_o}, 32'h0);
    check("R2 hold", result_o, held);
    @(negedge clk_i);
    check("R2 hold 2", result_o, held);

    // back-to-back strobes
    @(negedge clk_i);
    start_i = 1'b1; op_i = 1'b0; operand_i = 32'd5; rmode_i = 2'd0;
    @(negedge clk_i);
    check("R1 b2b valid", {31'b0, valid_o}, 32'h1);
    check("R3 b2b first", result_o, 32'h40A00000);
    op_i = 1'b1; operand_i = 32'h40A00000;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R3 b2b second", result_o, 32'd5);

    // random, per mode, exponent steered near the interesting ranges
    for (int n = 0; n < 4000; n++) begin
      logic        op;
      logic [31:0] x;
      logic [1:0]  rm;
      string       tg;
      op = 1'($urandom);
      rm = 2'($urandom);
      x  = $urandom;
      if (op && ($urandom % 4) != 0) x[30:23] = 8'(110 + ($urandom % 52));
      else if (!op && ($urandom % 2) == 0) x = x >> ($urandom % 32);
      tg = (rm == 2'd0) ? "R4 random" : (rm == 2'd1) ? "R5 random" : "R6 random";
      conv_ref(tg, op, x, rm);
    end

    finish_run();
  end
endmodule